// File: doc/BRIEF.md
# Keypad autorepeat event generator

This block sits between a key-matrix debouncer and the key-event queue of a keypad controller. While at least one key stays held it produces a repeat marker on a push strobe so the host learns that a key is being kept down, without the held key's own code ever being queued again. Time is counted in debounce-cycle ticks supplied by the scanner, not in clock cycles.

After each recorded key event (press or release) the block waits a programmable initial delay. If keys are still held at the end of it, one repeat marker is pushed. Further markers follow at a programmable interval until the next key event, which restarts the initial delay. Only one marker is produced per interval, however many keys are down.

An 8-bit configuration word holds an enable bit, a 4-bit delay field and a 3-bit interval field. Dropping the enable bit or releasing every key clears the timing state at once.

Top module: `keyrep_gen`

## Requirements
- R1: Bit 7 of the configuration word enables the block (1 = on). After reset, and on every cycle that follows a cycle with bit 7 at 0, the push strobe is 0.
- R2: Bits 3:0 (value d) set the initial delay to (d+1)*8 ticks counted after the most recent key event; the push strobe rises for one cycle on the clock cycle right after the cycle holding the tick that completes the delay.
- R3: Bits 6:4 (value r) set the repeat interval: after the first push, a further push follows every (r+1)*4 ticks while no key event arrives.
- R4: The push strobe lasts one clock cycle, and the code output carries 0x7E on that cycle and 0x00 on every other cycle; at most one code is pushed per completed interval.
- R5: A key-event strobe while a key is still held discards the running count and restarts the full initial delay, including after a release while other keys stay down.
- R6: When the any-key-held flag is 0 the count is cleared and no push follows; the next count starts again from the initial delay.
- R7: A key event in the same cycle as the tick that would complete an interval suppresses that push and reloads the initial delay.
- R8: Only cycles with the tick input high advance the count; cycles without a tick never produce a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse per completed debounce cycle |
| key_evt_i | input | 1 | One-cycle pulse when a key press or release is recorded |
| any_held_i | input | 1 | High while at least one key is down |
| cfg_i | input | 8 | Enable (bit 7), interval field (6:4), delay field (3:0) |
| push_o | output | 1 | Push request toward the event queue |
| push_code_o | output | 8 | Repeat marker 0x7E during a push, 0x00 otherwise |

## Verification
The bench aims at the exact tick that ends each window: a push one tick early or late points to an off-by-one in the limit compare or a wrong field scaling, most visible at the largest delay of 128 ticks. It fires a key event on the very tick a repeat falls due; a design that let the push through would queue a stale marker, and one that failed to reload would fire after the shorter interval. A release while keys stay held must bring back the long delay, so a design stuck in interval mode shows a push after only four ticks. Dropping the held flag without any event must also clear the count, or a later hold fires early from stale state.

// File: rtl/keyrep_pkg.sv
package keyrep_pkg;

   typedef enum logic {
      PH_DELAY = 1'b0,
      PH_RATE  = 1'b1
   } keyrep_phase_e;

   function automatic int unsigned kr_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned kr_min(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/keyrep_limit_dec.sv
module keyrep_limit_dec
   import keyrep_pkg::*;
#(
   parameter int unsigned CFG_W     = 8,
   parameter int unsigned EN_BIT    = 7,
   parameter int unsigned DLY_LSB   = 0,
   parameter int unsigned DLY_W     = 4,
   parameter int unsigned RATE_LSB  = 4,
   parameter int unsigned RATE_W    = 3,
   parameter int unsigned DLY_UNIT  = 8,
   parameter int unsigned RATE_UNIT = 4,
   parameter int unsigned CNT_W     = 8
) (
   input  logic [CFG_W-1:0] cfg_i,
   input  keyrep_phase_e    phase_i,
   output logic             enable_o,
   output logic [CNT_W-1:0] limit_o
);

   localparam bit DLY_POW2  = ((DLY_UNIT & (DLY_UNIT - 1)) == 0);
   localparam bit RATE_POW2 = ((RATE_UNIT & (RATE_UNIT - 1)) == 0);
   localparam int unsigned DLY_SH  = $clog2(DLY_UNIT);
   localparam int unsigned RATE_SH = $clog2(RATE_UNIT);

   logic [DLY_W-1:0]  dly_f;
   logic [RATE_W-1:0] rate_f;
   logic [CNT_W:0]    dly_n;
   logic [CNT_W:0]    rate_n;
   logic [CNT_W-1:0]  dly_lim;
   logic [CNT_W-1:0]  rate_lim;

   assign dly_f    = cfg_i[DLY_LSB +: DLY_W];
   assign rate_f   = cfg_i[RATE_LSB +: RATE_W];
   assign enable_o = cfg_i[EN_BIT];
   assign dly_n    = (CNT_W+1)'(dly_f) + (CNT_W+1)'(1);
   assign rate_n   = (CNT_W+1)'(rate_f) + (CNT_W+1)'(1);

   // Scaling: a shift when the unit is a power of two, a multiplier otherwise.
   generate
      if (DLY_POW2) begin : g_dly_shift
         assign dly_lim = CNT_W'(dly_n << DLY_SH);
      end else begin : g_dly_mul
         assign dly_lim = CNT_W'(dly_n * (CNT_W+1)'(DLY_UNIT));
      end
      if (RATE_POW2) begin : g_rate_shift
         assign rate_lim = CNT_W'(rate_n << RATE_SH);
      end else begin : g_rate_mul
         assign rate_lim = CNT_W'(rate_n * (CNT_W+1)'(RATE_UNIT));
      end
   endgenerate

   assign limit_o = (phase_i == PH_RATE) ? rate_lim : dly_lim;

endmodule

// File: rtl/keyrep_tick_cnt.sv
module keyrep_tick_cnt
   import keyrep_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output keyrep_phase_e    phase_o,
   output logic             due_o
);

   logic [CNT_W-1:0] cnt_q;
   keyrep_phase_e    phase_q;
   logic [CNT_W:0]   cnt_inc;
   logic             reach;

   assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
   // >= so that a limit lowered mid-count completes on the next tick
   assign reach   = (cnt_inc >= {1'b0, limit_i});
   assign due_o   = !clr_i && tick_i && reach;
   assign phase_o = phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         cnt_q   <= '0;
         phase_q <= PH_DELAY;
      end else if (tick_i) begin
         if (reach) begin
            cnt_q   <= '0;
            phase_q <= PH_RATE;
         end else begin
            cnt_q   <= cnt_inc[CNT_W-1:0];
         end
      end
   end

endmodule

// File: rtl/keyrep_out_stage.sv
module keyrep_out_stage #(
   parameter int unsigned CODE_W = 8,
   parameter logic [CODE_W-1:0] CODE = 8'h7E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              due_i,
   output logic              push_o,
   output logic [CODE_W-1:0] push_code_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         push_o      <= 1'b0;
         push_code_o <= '0;
      end else begin
         push_o      <= due_i;
         push_code_o <= due_i ? CODE : '0;
      end
   end

endmodule

// File: rtl/keyrep_gen.sv
module keyrep_gen
   import keyrep_pkg::*;
#(
   parameter int unsigned CFG_W     = 8,
   parameter int unsigned EN_BIT    = 7,
   parameter int unsigned DLY_LSB   = 0,
   parameter int unsigned DLY_W     = 4,
   parameter int unsigned RATE_LSB  = 4,
   parameter int unsigned RATE_W    = 3,
   parameter int unsigned DLY_UNIT  = 8,
   parameter int unsigned RATE_UNIT = 4,
   parameter int unsigned CODE_W    = 8,
   parameter logic [CODE_W-1:0] CODE = 8'h7E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              key_evt_i,
   input  logic              any_held_i,
   input  logic [CFG_W-1:0]  cfg_i,
   output logic              push_o,
   output logic [CODE_W-1:0] push_code_o
);

   localparam int unsigned MAX_LIM = kr_max((2**DLY_W) * DLY_UNIT, (2**RATE_W) * RATE_UNIT);
   localparam int unsigned MIN_LIM = kr_min(DLY_UNIT, RATE_UNIT);
   localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);

   generate
      if (EN_BIT >= CFG_W) begin : g_bad_en
         $error("keyrep_gen: enable bit outside configuration word");
      end
      if (DLY_LSB + DLY_W > CFG_W || RATE_LSB + RATE_W > CFG_W) begin : g_bad_field
         $error("keyrep_gen: field outside configuration word");
      end
      if (DLY_UNIT < 1 || RATE_UNIT < 1) begin : g_bad_unit
         $error("keyrep_gen: tick units must be at least one");
      end
      if (DLY_W < 1 || RATE_W < 1 || CODE_W < 1) begin : g_bad_width
         $error("keyrep_gen: zero-width field");
      end
   endgenerate

   keyrep_phase_e    phase;
   logic             enable;
   logic [CNT_W-1:0] limit;
   logic             clr;
   logic             due;

   // Counting is held at zero when disabled, when nothing is held, or on any key event.
   assign clr = !enable || !any_held_i || key_evt_i;

   keyrep_limit_dec #(
      .CFG_W(CFG_W), .EN_BIT(EN_BIT), .DLY_LSB(DLY_LSB), .DLY_W(DLY_W),
      .RATE_LSB(RATE_LSB), .RATE_W(RATE_W), .DLY_UNIT(DLY_UNIT),
      .RATE_UNIT(RATE_UNIT), .CNT_W(CNT_W)
   ) u_dec (
      .cfg_i    (cfg_i),
      .phase_i  (phase),
      .enable_o (enable),
      .limit_o  (limit)
   );

   keyrep_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .tick_i  (tick_i),
      .limit_i (limit),
      .phase_o (phase),
      .due_o   (due)
   );

   keyrep_out_stage #(.CODE_W(CODE_W), .CODE(CODE)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .due_i       (due),
      .push_o      (push_o),
      .push_code_o (push_code_o)
   );

endmodule

// File: rtl/keyrep_gen_chk.sv
module keyrep_gen_chk #(
   parameter int unsigned CODE_W  = 8,
   parameter logic [CODE_W-1:0] CODE = 8'h7E,
   parameter int unsigned MIN_LIM = 4,
   parameter int unsigned MAX_LIM = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              key_evt_i,
   input logic              any_held_i,
   input logic              en_i,
   input logic              push_o,
   input logic [CODE_W-1:0] push_code_o
);

   localparam int unsigned SW = $clog2(MAX_LIM + 2);

   logic [SW-1:0] seen;
   logic [SW-1:0] base;

   // Ticks observed since the last event, idle cycle or push.
   assign base = push_o ? '0 : seen;

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i || !any_held_i || key_evt_i) begin
         seen <= '0;
      end else if (tick_i) begin
         seen <= base + SW'(1);
      end else begin
         seen <= base;
      end
   end

   p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !push_o);

   p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |-> (seen >= SW'(MIN_LIM)) && (seen <= SW'(MAX_LIM)));

   p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seen <= SW'(MAX_LIM));

   p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push_o |=> !push_o);

   p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push_code_o == (push_o ? CODE : '0));

   p_evt_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      key_evt_i |=> !push_o);

   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !any_held_i |=> !push_o);

   p_tick_needed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> !push_o);

endmodule

bind keyrep_gen keyrep_gen_chk #(
   .CODE_W  (CODE_W),
   .CODE    (CODE),
   .MIN_LIM (MIN_LIM),
   .MAX_LIM (MAX_LIM)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick_i      (tick_i),
   .key_evt_i   (key_evt_i),
   .any_held_i  (any_held_i),
   .en_i        (cfg_i[EN_BIT]),
   .push_o      (push_o),
   .push_code_o (push_code_o)
);

// File: tb/keyrep_gen_test.sv
module keyrep_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       evt = 1'b0;
   logic       held = 1'b0;
   logic [7:0] cfg = 8'h00;
   logic       push;
   logic [7:0] code;

   int checks = 0;
   int fails  = 0;
   int pcount = 0;
   int m_cnt  = 0;
   bit m_rate = 1'b0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   keyrep_gen uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick),
      .key_evt_i   (evt),
      .any_held_i  (held),
      .cfg_i       (cfg),
      .push_o      (push),
      .push_code_o (code)
   );

   function automatic int dly_ticks(input logic [7:0] c);
      return (int'(c[3:0]) + 1) * 8;
   endfunction

   function automatic int rate_ticks(input logic [7:0] c);
      return (int'(c[6:4]) + 1) * 4;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Apply inputs for one cycle, then observe the push they cause.
   task automatic step(input logic t, input logic e, input logic h);
      bit exp;
      int lim;
      tick = t; evt = e; held = h;
      exp = 1'b0;
      if (!cfg[7] || !h || e) begin
         m_cnt = 0; m_rate = 1'b0;
      end else if (t) begin
         lim = m_rate ? rate_ticks(cfg) : dly_ticks(cfg);
         if (m_cnt + 1 >= lim) begin
            exp = 1'b1; m_cnt = 0; m_rate = 1'b1;
         end else begin
            m_cnt++;
         end
      end
      @(negedge clk);
      checks++;
      if (push !== exp || code !== (exp ? 8'h7E : 8'h00)) begin
         fails++;
         $display("FAIL R2/R3/R4 model: actual push=%0b code=%02h expected push=%0b code=%02h",
                  push, code, exp, exp ? 8'h7E : 8'h00);
      end
      if (push === 1'b1) pcount++;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b1);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      int p0;
      void'($urandom(32'h5EED_1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset push", int'(push), 0);
      chk("R4 reset code", int'(code), 0);

      // R1: disabled, keys held, many ticks
      cfg = 8'h0F;
      step(1'b0, 1'b1, 1'b1);
      p0 = pcount; ticks(200);
      chk("R1 disabled no push", pcount - p0, 0);

      // R2/R3: shortest delay 8, interval 4
      cfg = 8'h80;
      step(1'b0, 1'b1, 1'b1);
      p0 = pcount; ticks(7);
      chk("R2 none before 8 ticks", pcount - p0, 0);
      ticks(1);
      chk("R2 first push at 8 ticks", pcount - p0, 1);
      ticks(3);
      chk("R3 none before 4 more", pcount - p0, 1);
      ticks(1);
      chk("R3 repeat at 4 ticks", pcount - p0, 2);

      // R5: release while others held brings back the long delay
      step(1'b0, 1'b1, 1'b1);
      p0 = pcount; ticks(4);
      chk("R5 no interval after release", pcount - p0, 0);
      ticks(4);
      chk("R5 delay after release", pcount - p0, 1);

      // R2/R3: largest delay 128, interval 32
      cfg = 8'hFF;
      step(1'b0, 1'b1, 1'b1);
      p0 = pcount; ticks(127);
      chk("R2 none before 128", pcount - p0, 0);
      ticks(1);
      chk("R2 push at 128", pcount - p0, 1);
      ticks(31);
      chk("R3 none before 32", pcount - p0, 1);
      ticks(1);
      chk("R3 push at 32", pcount - p0, 2);

      // R8: cycles without tick do not count
      cfg = 8'h80;
      step(1'b0, 1'b1, 1'b1);
      p0 = pcount;
      for (int i = 0; i < 7; i++) begin
         step(1'b1, 1'b0, 1'b1);
         repeat (3) step(1'b0, 1'b0, 1'b1);
      end
      chk("R8 gaps not counted", pcount - p0, 0);
      ticks(1);
      chk("R8 push on eighth tick", pcount - p0, 1);

      // R5: event mid-delay restarts count
      step(1'b0, 1'b1, 1'b1);
      p0 = pcount; ticks(5);
      step(1'b0, 1'b1, 1'b1);
      ticks(7);
      chk("R5 restart mid-delay", pcount - p0, 0);
      ticks(1);
      chk("R5 push after full delay", pcount - p0, 1);

      // R7: event on the due tick suppresses and reloads
      step(1'b0, 1'b1, 1'b1);
      p0 = pcount; ticks(7);
      step(1'b1, 1'b1, 1'b1);
      chk("R7 coincident push suppressed", pcount - p0, 0);
      ticks(7);
      chk("R7 reload delay", pcount - p0, 0);
      ticks(1);
      chk("R7 push after reload", pcount - p0, 1);

      // R6: nothing held clears the count
      step(1'b0, 1'b1, 1'b1);
      p0 = pcount; ticks(5);
      step(1'b1, 1'b0, 1'b0);
      ticks(3);
      chk("R6 count cleared by idle", pcount - p0, 0);
      ticks(5);
      chk("R6 delay from zero", pcount - p0, 1);
      p0 = pcount;
      for (int i = 0; i < 50; i++) step(1'b1, 1'b0, 1'b0);
      chk("R6 no push when idle", pcount - p0, 0);

      // Random mix checked against the bench model every cycle
      for (int blk = 0; blk < 8; blk++) begin
         cfg = {($urandom_range(0, 7) != 0), 3'($urandom_range(0, 2)), 4'($urandom_range(0, 2))};
         for (int i = 0; i < 500; i++) begin
            step(($urandom_range(0, 1) == 1), ($urandom_range(0, 29) == 0),
                 ($urandom_range(0, 19) != 0));
         end
      end

      done = 1'b1;
      summary();
   end

endmodule